// File: doc/BRIEF.md
# Programmable Input Deglitch Filter Bank

This block cleans up a bank of byte-wide digital input ports before anything downstream samples them. Every input bit first passes through a two-stage synchronizer. After that, the channel's own enable bit picks one of two paths to the output. With the bit clear, the synchronized level goes straight through. With the bit set, the output is a filtered level. The filtered level moves to a new value only after the synchronized input has held that value for a programmable number of 200 ns ticks in a row.

All channels on all ports share one 20-bit stability interval. Each port has its own 8-bit enable register, with one bit per channel. A free-running divider turns the system clock into the 200 ns tick; the `CLKS_PER_TICK` parameter sets how many clocks make one tick. Registers are written through a simple write strobe that carries an access-size flag (word or byte). They are read back through a separate combinational read port.

Top module: `deglitch_bank`

## Requirements
- R1: After reset the interval register reads 0, every enable register reads 0, and each output bit equals its synchronized raw input.
- R2: The interval is written by a word access (`bus_word`=1) at address 0x08. Only data bits 19:0 are kept, bits 31:20 are discarded, and a read at 0x08 returns the field zero-extended. A byte access at 0x08 leaves the interval unchanged.
- R3: The enable register of port p sits at address 0x44 + 0x10·p and is written by a byte access (`bus_word`=0) from data bits 7:0. Its bit k controls output bit 8·p+k. A read returns it in bits 7:0, and a word access at that address leaves it unchanged.
- R4: A channel whose enable bit is 0 drives its synchronized raw input, two clocks after the input changes, whatever the interval value is.
- R5: For a channel whose enable bit is 1 and a nonzero interval N, the output takes a new level only after the synchronized input has differed from the output for N consecutive ticks, where one tick is `CLKS_PER_TICK` clocks (200 ns).
- R6: A pulse shorter than the interval never reaches the output of an enabled channel. Any return of the input to the current output level restarts that channel's count from zero.
- R7: With an interval of 0, an enabled channel follows its synchronized input within one extra clock, with no tick delay.
- R8: Every interval write restarts the stability count of every channel, so a partly elapsed count is dropped.
- R9: While a channel is disabled, its filtered level tracks the synchronized input. Setting its enable bit therefore shows the present input level at once, with no wait of one interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_word | input | 1 | Access size: 1 = 32-bit word, 0 = byte |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 32 | Write data (bits 7:0 for byte access) |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| pin_in | input | 8·NUM_PORTS | Raw asynchronous inputs |
| pin_out | output | 8·NUM_PORTS | Filtered or raw-pass outputs |

## Verification
On every cycle, the assertions check the following. An enabled channel with a nonzero interval keeps its filtered level between ticks and on a restart cycle. A channel's count never reaches the interval. An interval write clears every count and loads the written field. An interval of zero makes the filtered level follow the synchronizer. Ticks never fall on two clocks in a row.

Only the bench's scenarios can show how the outputs time out against a whole interval at the ports. Those scenarios cover:
- rejection of short pulses, and the restart when the input returns to the output level;
- the delay added when the interval is rewritten partway through a count;
- the immediate level seen when a channel is enabled;
- the address and access-size decode of the registers.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
  localparam int IVL_W = 20;
  localparam logic [7:0] IVL_ADDR = 8'h08;
  localparam int PORT_BASE   = 64;
  localparam int PORT_STRIDE = 16;
  localparam int EN_OFS      = 4;

  // address of the per-port enable byte
  function automatic logic [7:0] en_addr(input int p);
    return 8'(PORT_BASE + PORT_STRIDE * p + EN_OFS);
  endfunction

  // interval field carried by a word write
  function automatic logic [IVL_W-1:0] ivl_field(input logic [31:0] w);
    return w[IVL_W-1:0];
  endfunction

  // true when one more tick completes the interval
  function automatic logic count_done(input logic [IVL_W-1:0] c,
                                      input logic [IVL_W-1:0] i);
    return ({1'b0, c} + (IVL_W+1)'(1)) >= {1'b0, i};
  endfunction
endpackage

// File: rtl/dgl_tick.sv
module dgl_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    end
  endgenerate
endmodule

// File: rtl/dgl_regs.sv
module dgl_regs
  import dgl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int NCH = NUM_PORTS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             word,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [7:0]       raddr,
  output logic [31:0]      rdata,
  output logic [IVL_W-1:0] ivl,
  output logic [NCH-1:0]   en,
  output logic             restart
);
  assign restart = wr && word && (addr == IVL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)       ivl <= '0;
    else if (restart) ivl <= ivl_field(wdata);
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
      wire hit = wr && !word && (addr == en_addr(p));
      always_ff @(posedge clk) begin
        if (!rst_n)   en[p*8 +: 8] <= '0;
        else if (hit) en[p*8 +: 8] <= wdata[7:0];
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (raddr == IVL_ADDR) rdata = {{(32-IVL_W){1'b0}}, ivl};
    for (int p = 0; p < NUM_PORTS; p++)
      if (raddr == en_addr(p)) rdata = {24'b0, en[p*8 +: 8]};
  end

  AST_IVL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ivl == $past(wdata[IVL_W-1:0])); // R2
endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
  import dgl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             en,
  input  logic             tick,
  input  logic             restart,
  input  logic [IVL_W-1:0] ivl,
  output logic             dout
);
  logic             state;
  logic [IVL_W-1:0] cnt;

  wire ivl_zero = (ivl == '0);
  wire differs  = (sync_in != state);
  wire reached  = count_done(cnt, ivl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= 1'b0;
      cnt   <= '0;
    end else if (!en || ivl_zero) begin
      state <= sync_in;
      cnt   <= '0;
    end else if (restart || !differs) begin
      cnt   <= '0;
    end else if (tick) begin
      if (reached) begin
        state <= sync_in;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dout = en ? state : sync_in;

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ivl_zero && (!tick || restart)) |=> $stable(state)); // R5
  AST_CNT_BELOW_IVL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) || (cnt < ivl)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0); // R8
  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ivl_zero) |=> state == $past(sync_in)); // R7
endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
  import dgl_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int CLKS_PER_TICK = 10,
  localparam int NCH = NUM_PORTS * 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_word,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic [7:0]     bus_raddr,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_out
);
  logic [NCH-1:0]   meta_q, sync_q;
  logic [IVL_W-1:0] ivl;
  logic [NCH-1:0]   en;
  logic             restart;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  dgl_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  dgl_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .word(bus_word),
    .addr(bus_addr), .wdata(bus_wdata), .raddr(bus_raddr),
    .rdata(bus_rdata), .ivl(ivl), .en(en), .restart(restart)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      dgl_chan u_chan (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q[c]), .en(en[c]),
        .tick(tick), .restart(restart), .ivl(ivl), .dout(pin_out[c])
      );
    end
  endgenerate

  AST_RAW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (pin_out == sync_q)); // R4
endmodule

// File: tb/sim_deglitch_bank.sv
module sim_deglitch_bank;
  localparam int NP  = 4;
  localparam int DIV = 10;
  localparam int NCH = NP * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_word = 1'b0;
  logic [7:0]     bus_addr = '0, bus_raddr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] pin_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  deglitch_bank #(.NUM_PORTS(NP), .CLKS_PER_TICK(DIV)) u0 (.*);

  function automatic logic [7:0] ea(input int p);
    return 8'(8'h44 + 8'h10 * p);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_raddr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd("R1 interval", 8'h08, 32'h0);
    for (int p = 0; p < NP; p++) rd("R1 enable", ea(p), 32'h0);
    pin_in = 32'h5A3C_0F81;
    cyc(3);
    chk("R1 raw pass", pin_out, 32'h5A3C_0F81);
    pin_in = '0;
    cyc(3);
  endtask

  task automatic t_regs;
    wr(1'b1, 8'h08, 32'hFFFF_FFFF);
    rd("R2 upper bits dropped", 8'h08, 32'h000F_FFFF);
    wr(1'b1, 8'h08, 32'h0012_3456);
    rd("R2 field", 8'h08, 32'h0002_3456);
    wr(1'b0, 8'h08, 32'h0000_0011);
    rd("R2 byte ignored", 8'h08, 32'h0002_3456);
    wr(1'b0, ea(2), 32'h0000_00A5);
    rd("R3 enable readback", ea(2), 32'h0000_00A5);
    wr(1'b1, ea(1), 32'h0000_00FF);
    rd("R3 word ignored", ea(1), 32'h0);
    wr(1'b0, ea(2), 32'h0);
    rd("R3 enable cleared", ea(2), 32'h0);
  endtask

  task automatic t_raw_pass;
    wr(1'b1, 8'h08, 32'd5);
    pin_in[20] = 1'b1;
    cyc(2);
    chk("R4 disabled passes raw", 32'(pin_out[20]), 32'd1);
    pin_in[20] = 1'b0;
    cyc(3);
  endtask

  task automatic t_filter;
    wr(1'b1, 8'h08, 32'd5);
    wr(1'b0, ea(0), 32'h0000_00FF);
    pin_in[0] = 1'b1;
    pin_in[8] = 1'b1;
    cyc(3);
    chk("R3 port1 unaffected", 32'(pin_out[8]), 32'd1);
    cyc(37);
    chk("R5 held before interval", 32'(pin_out[0]), 32'd0);
    cyc(14);
    chk("R5 changed after interval", 32'(pin_out[0]), 32'd1);
    pin_in[8] = 1'b0;
    cyc(3);
  endtask

  task automatic t_glitch;
    pin_in[1] = 1'b1;
    cyc(20);
    pin_in[1] = 1'b0;
    cyc(80);
    chk("R6 short pulse rejected", 32'(pin_out[1]), 32'd0);
    pin_in[1] = 1'b1;
    cyc(30);
    pin_in[1] = 1'b0;
    cyc(3);
    pin_in[1] = 1'b1;
    cyc(30);
    pin_in[1] = 1'b0;
    cyc(3);
    chk("R6 return restarts count", 32'(pin_out[1]), 32'd0);
    cyc(60);
    chk("R6 still quiet", 32'(pin_out[1]), 32'd0);
  endtask

  task automatic t_zero;
    wr(1'b1, 8'h08, 32'd0);
    pin_in[2] = 1'b1;
    cyc(3);
    chk("R7 zero interval follows", 32'(pin_out[2]), 32'd1);
    pin_in[2] = 1'b0;
    cyc(3);
    chk("R7 zero interval falls", 32'(pin_out[2]), 32'd0);
  endtask

  task automatic t_restart;
    wr(1'b1, 8'h08, 32'd5);
    pin_in[3] = 1'b1;
    cyc(30);
    wr(1'b1, 8'h08, 32'd5);
    cyc(39);
    chk("R8 count restarted", 32'(pin_out[3]), 32'd0);
    cyc(15);
    chk("R8 changes after full interval", 32'(pin_out[3]), 32'd1);
  endtask

  task automatic t_enable_now;
    pin_in[9] = 1'b1;
    cyc(3);
    wr(1'b0, ea(1), 32'h0000_0002);
    chk("R9 enable shows current level", 32'(pin_out[9]), 32'd1);
    cyc(5);
    chk("R9 level kept", 32'(pin_out[9]), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all-requirements actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_raw_pass();
    t_filter();
    t_glitch();
    t_zero();
    t_restart();
    t_enable_now();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule